// File: doc/BRIEF.md
# Video Processor Host Port

This block is the processor-facing side of a tile-and-sprite video processor. The processor sees two ports, selected by one address line: a data port and a command port. Two writes in a row to the command port make up one command. Depending on the top bits of the second byte, that command either loads one of eight write-only control registers or sets a 14-bit video memory address. Data-port writes store into video memory. Data-port reads return bytes from a read-ahead buffer. The address moves forward by one after every data access.

A read of the command port returns a status byte. It carries the frame flag, the fifth-sprite flag with the sprite index, and the collision flag, and the read clears the three flags. The frame flag drives the interrupt output when the enable bit in control register 1 is set. The pixel pipeline raises the flags through single-cycle event inputs. Video memory sits behind a plain synchronous port with enable and write-enable signals and one cycle of read latency.

Top module: `vid_host_port`

## Requirements
- R1: After reset, all eight control registers are 0x00, the status byte reads 0x00, `irq` is low, the command toggle is at the first byte, and no video memory access is issued.
- R2: When a second command byte has bit 7 set, the control register numbered by its bits 2:0 takes the first byte on the next cycle, whatever bits 6:3 hold. Register n is presented on `ctrl_regs[8n+7:8n]`.
- R3: When a second command byte has bits 7:6 = 01, the current address becomes {second[5:0], first}. No video memory access is issued.
- R4: A data-port write issues one video memory write of that byte at the current address, on the cycle after the strobe. The current address then increments by one.
- R5: The current address wraps from 0x3FFF to 0x0000.
- R6: When a second command byte has bits 7:6 = 00, the address is set as in R3 and one byte is fetched into the read buffer. A data-port read returns the buffered byte in the strobe cycle, then fetches the byte at the current address and increments the address.
- R7: The status byte has bit 7 = frame flag, bit 6 = fifth-sprite flag, bit 5 = collision flag and bits 4:0 = sprite index. The index is taken from `fifth_idx` only when a fifth-sprite event arrives while that flag is clear.
- R8: A status read returns the flags as they stood before the read and clears bits 7:5 from the next cycle on. An event that arrives in the same cycle as the read still sets its flag. The index is kept.
- R9: `irq` is high exactly while the frame flag is set and bit 5 of control register 1 is set.
- R10: A status read or any data-port access returns the command toggle to the first byte, so the next command write counts as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe |
| host_cmd | input | 1 | 1 selects the command/status port, 0 selects the data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data: status when host_cmd is 1, read buffer when it is 0 |
| ctrl_regs | output | 64 | The eight control registers, register n in bits 8n+7:8n |
| frame_evt | input | 1 | One-cycle frame event from the pixel pipeline |
| fifth_evt | input | 1 | One-cycle fifth-sprite event |
| fifth_idx | input | 5 | Sprite index that goes with fifth_evt |
| coll_evt | input | 1 | One-cycle collision event |
| irq | output | 1 | Frame interrupt request, active high |
| vram_en | output | 1 | Video memory access enable |
| vram_we | output | 1 | Video memory write enable |
| vram_addr | output | 14 | Video memory address |
| vram_wdata | output | 8 | Video memory write data |
| vram_rdata | input | 8 | Video memory read data, valid one cycle after a read enable |

## Verification
The assertions take for granted that `host_wr` and `host_rd` are never high in the same cycle. They also assume that host strobes are at least five cycles apart, so a fetch finishes before the next data read. Both matter for the toggle and fetch checks. The bench drives every access through one task that raises a single strobe for one cycle and then idles seven cycles. Event pulses are placed in idle cycles, except in one directed case that puts an event in the same cycle as a status read on purpose.

// File: rtl/vhp_pkg.sv
// Package: shared types for the video processor host port.
// Assumes byte-wide host data; command decoding uses the top two bits of a byte.
package vhp_pkg;
    // Kind of a completed two-byte command, taken from bits 7:6 of the second byte.
    typedef enum logic [1:0] {
        CMD_RD_ADDR = 2'b00,
        CMD_WR_ADDR = 2'b01,
        CMD_REG_LO  = 2'b10,
        CMD_REG_HI  = 2'b11
    } cmd_kind_e;
endpackage

// File: rtl/vhp_cmd_latch.sv
// Module: two-write command latch and decoder.
// Holds the first command byte and a first/second toggle. On the second write
// it decodes either a register load or an address load, for one cycle.
// Assumes a single host access per cycle.
module vhp_cmd_latch import vhp_pkg::*; #(
    parameter int DW  = 8,
    parameter int AW  = 14,
    parameter int RIW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_wr,
    input  logic [DW-1:0]  wdata,
    input  logic           clr_tog,
    output logic           reg_we,
    output logic [RIW-1:0] reg_idx,
    output logic [DW-1:0]  reg_data,
    output logic           addr_ld,
    output logic           addr_pf,
    output logic [AW-1:0]  addr_val
);
    localparam int HIW = AW - DW;

    logic          tog_q;
    logic [DW-1:0] lo_q;
    logic          second;
    cmd_kind_e     kind;

    assign second = cmd_wr & tog_q;
    assign kind   = cmd_kind_e'(wdata[DW-1:DW-2]);

    // Purpose: track the byte toggle and keep the first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
            lo_q  <= '0;
        end else if (clr_tog) begin
            tog_q <= 1'b0;
        end else if (cmd_wr) begin
            if (!tog_q) lo_q <= wdata;
            tog_q <= ~tog_q;
        end
    end

    // Purpose: decode the completed command from the second byte.
    always_comb begin
        reg_we   = 1'b0;
        addr_ld  = 1'b0;
        addr_pf  = 1'b0;
        reg_idx  = wdata[RIW-1:0];
        reg_data = lo_q;
        addr_val = {wdata[HIW-1:0], lo_q};
        if (second) begin
            case (kind)
                CMD_RD_ADDR: begin addr_ld = 1'b1; addr_pf = 1'b1; end
                CMD_WR_ADDR: addr_ld = 1'b1;
                default:     reg_we  = 1'b1;
            endcase
        end
    end

    // R10: a reset request always leaves the toggle at the first byte.
    a_r10_toggle_reset: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tog |=> !tog_q);
    // R2: a register load only follows a stored first byte.
    a_r2_load_on_second: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !tog_q);
endmodule

// File: rtl/vhp_ctrl_regs.sv
// Module: bank of write-only control registers.
// One register is written per cycle, chosen by index. All are presented
// flattened, register n in slice n. Assumes NREG <= 2**RIW.
module vhp_ctrl_regs #(
    parameter int DW   = 8,
    parameter int NREG = 8,
    parameter int RIW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [RIW-1:0]   idx,
    input  logic [DW-1:0]    data,
    output logic [NREG*DW-1:0] regs_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r_q;

        // Purpose: load register g when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                          r_q <= '0;
            else if (we && idx == RIW'(g))        r_q <= data;
        end

        assign regs_flat[g*DW +: DW] = r_q;

        // R2: an addressed register presents the loaded byte on the next cycle.
        a_r2_reg_load: assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx == RIW'(g)) |=> regs_flat[g*DW +: DW] == $past(data));
    end
endmodule

// File: rtl/vhp_vram_seq.sv
// Module: video memory address counter, access sequencer and read buffer.
// Issues registered single-cycle accesses. Read data is expected one cycle
// after a read enable. Assumes host data accesses are at least five cycles
// apart so that each fetch lands before the next read.
module vhp_vram_seq #(
    parameter int DW = 8,
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_ld,
    input  logic          addr_pf,
    input  logic [AW-1:0] addr_val,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rbuf,
    output logic          vram_en,
    output logic          vram_we,
    output logic [AW-1:0] vram_addr,
    output logic [DW-1:0] vram_wdata,
    input  logic [DW-1:0] vram_rdata
);
    logic [AW-1:0] cur_q;
    logic          pend_q;
    logic          fetch_q;

    // Purpose: sequence writes, fetches, the address step and the buffer load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= '0;
            pend_q     <= 1'b0;
            fetch_q    <= 1'b0;
            rbuf       <= '0;
            vram_en    <= 1'b0;
            vram_we    <= 1'b0;
            vram_addr  <= '0;
            vram_wdata <= '0;
        end else begin
            vram_en <= 1'b0;
            vram_we <= 1'b0;
            fetch_q <= vram_en & ~vram_we;
            if (fetch_q) rbuf <= vram_rdata;
            if (addr_ld) begin
                cur_q  <= addr_val;
                pend_q <= addr_pf;
            end else if (data_wr) begin
                vram_en    <= 1'b1;
                vram_we    <= 1'b1;
                vram_addr  <= cur_q;
                vram_wdata <= wdata;
                cur_q      <= cur_q + 1'b1;
            end else if (data_rd) begin
                pend_q <= 1'b1;
            end else if (pend_q) begin
                vram_en   <= 1'b1;
                vram_addr <= cur_q;
                cur_q     <= cur_q + 1'b1;
                pend_q    <= 1'b0;
            end
        end
    end

    // R4: every memory write traces back to a host data write.
    a_r4_write_from_host: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_en && vram_we) |-> $past(data_wr));
    // R5: a data write steps the address by one, modulo the address space.
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> cur_q == AW'($past(cur_q) + 1'b1));
    // R3: an address load alone starts no memory access next cycle.
    a_r3_no_access_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ld |=> !vram_en);
    // R6: a memory read is only issued for a pending fetch.
    a_r6_read_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_en && !vram_we) |-> $past(pend_q));
endmodule

// File: rtl/vhp_status.sv
// Module: status flags for frame, fifth sprite and collision, plus the sprite index.
// Events set flags; a status read clears them on the next edge, and an event
// in the same cycle wins. Assumes events are single-cycle pulses.
module vhp_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stat,
    input  logic          frame_evt,
    input  logic          fifth_evt,
    input  logic [DW-4:0] fifth_idx,
    input  logic          coll_evt,
    output logic [DW-1:0] stat,
    output logic          frame_flag
);
    logic          fifth_q;
    logic          coll_q;
    logic [DW-4:0] idx_q;

    // Purpose: set flags on events, clear them after a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_flag <= 1'b0;
            fifth_q    <= 1'b0;
            coll_q     <= 1'b0;
            idx_q      <= '0;
        end else begin
            frame_flag <= frame_evt | (frame_flag & ~rd_stat);
            fifth_q    <= fifth_evt | (fifth_q & ~rd_stat);
            coll_q     <= coll_evt  | (coll_q  & ~rd_stat);
            if (fifth_evt && (!fifth_q || rd_stat)) idx_q <= fifth_idx;
        end
    end

    assign stat = {frame_flag, fifth_q, coll_q, idx_q};

    // R8: a status read without a new frame event clears the frame flag.
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !frame_evt) |=> !frame_flag);
    // R8: a same-cycle event is not lost.
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |=> frame_flag);
    // R7: the index holds while the fifth-sprite flag stays set.
    a_r7_index_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fifth_q && !rd_stat) |=> $stable(idx_q));
endmodule

// File: rtl/vid_host_port.sv
// Module: host port of the video processor (top).
// Splits host strobes into command, status and data accesses and wires the
// command latch, control registers, memory sequencer and status flags.
// Assumes one strobe per cycle and strobes at least five cycles apart.
module vid_host_port #(
    parameter int DW     = 8,
    parameter int AW     = 14,
    parameter int NREG   = 8,
    parameter int IE_BIT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic               host_cmd,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    output logic [NREG*DW-1:0] ctrl_regs,
    input  logic               frame_evt,
    input  logic               fifth_evt,
    input  logic [DW-4:0]      fifth_idx,
    input  logic               coll_evt,
    output logic               irq,
    output logic               vram_en,
    output logic               vram_we,
    output logic [AW-1:0]      vram_addr,
    output logic [DW-1:0]      vram_wdata,
    input  logic [DW-1:0]      vram_rdata
);
    localparam int RIW = $clog2(NREG);

    logic           cmd_wr, rd_stat, data_wr, data_rd, clr_tog;
    logic           reg_we, addr_ld, addr_pf, frame_flag;
    logic [RIW-1:0] reg_idx;
    logic [DW-1:0]  reg_data, stat, rbuf;
    logic [AW-1:0]  addr_val;

    assign cmd_wr  = host_wr & host_cmd;
    assign rd_stat = host_rd & host_cmd;
    assign data_wr = host_wr & ~host_cmd;
    assign data_rd = host_rd & ~host_cmd;
    assign clr_tog = rd_stat | data_wr | data_rd;

    vhp_cmd_latch #(.DW(DW), .AW(AW), .RIW(RIW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(host_wdata),
        .clr_tog(clr_tog), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_data(reg_data), .addr_ld(addr_ld), .addr_pf(addr_pf),
        .addr_val(addr_val));

    vhp_ctrl_regs #(.DW(DW), .NREG(NREG), .RIW(RIW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx),
        .data(reg_data), .regs_flat(ctrl_regs));

    vhp_vram_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_pf(addr_pf),
        .addr_val(addr_val), .data_wr(data_wr), .data_rd(data_rd),
        .wdata(host_wdata), .rbuf(rbuf), .vram_en(vram_en),
        .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
        .vram_rdata(vram_rdata));

    vhp_status #(.DW(DW)) u_stat (
        .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .frame_evt(frame_evt),
        .fifth_evt(fifth_evt), .fifth_idx(fifth_idx), .coll_evt(coll_evt),
        .stat(stat), .frame_flag(frame_flag));

    // Purpose: pick status or buffered data for the host read.
    assign host_rdata = host_cmd ? stat : rbuf;
    // Purpose: gate the frame flag with the enable bit of register 1.
    assign irq = frame_flag & ctrl_regs[DW + IE_BIT];

    // R9: with the enable bit clear on the previous cycle, a request stays low.
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_regs[DW + IE_BIT]) && !$past(reg_we) |-> !irq);
    // R1: a single strobe per cycle is assumed.
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd));
endmodule

// File: tb/vid_host_port_tb.sv
module vid_host_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0, host_rd = 1'b0, host_cmd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [63:0] ctrl_regs;
    logic frame_evt = 1'b0, fifth_evt = 1'b0, coll_evt = 1'b0;
    logic [4:0] fifth_idx = '0;
    logic irq, vram_en, vram_we;
    logic [13:0] vram_addr;
    logic [7:0] vram_wdata, vram_rdata;

    int nchk = 0, nerr = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [13:0] last_waddr;
    logic [7:0]  last_wdata;
    logic [7:0]  mem [1024];
    logic [7:0]  ref_mem [1024];
    logic [7:0]  ref_regs [8];

    always #10 clk = ~clk;

    vid_host_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_cmd(host_cmd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ctrl_regs(ctrl_regs), .frame_evt(frame_evt), .fifth_evt(fifth_evt),
        .fifth_idx(fifth_idx), .coll_evt(coll_evt), .irq(irq),
        .vram_en(vram_en), .vram_we(vram_we), .vram_addr(vram_addr),
        .vram_wdata(vram_wdata), .vram_rdata(vram_rdata));

    // Memory model, 1K aliased, one cycle read latency.
    always @(posedge clk) begin
        if (vram_en) begin
            if (vram_we) begin
                mem[vram_addr[9:0]] <= vram_wdata;
                last_waddr <= vram_addr;
                last_wdata <= vram_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
            vram_rdata <= mem[vram_addr[9:0]];
        end
    end

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 7 + 3);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic cmd, input logic wr, input logic [7:0] d,
                          output logic [7:0] rd);
        @(negedge clk);
        host_cmd = cmd; host_wr = wr; host_rd = ~wr; host_wdata = d;
        #2 rd = host_rdata;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cmd_wr(input logic [7:0] d);
        logic [7:0] dummy;
        access(1'b1, 1'b1, d, dummy);
    endtask

    task automatic set_reg(input int idx, input logic [7:0] v, input logic [7:0] junk);
        cmd_wr(v);
        cmd_wr(8'h80 | (junk & 8'h78) | 8'(idx));
        ref_regs[idx] = v;
    endtask

    task automatic set_addr(input logic [13:0] a, input logic rd_mode);
        cmd_wr(a[7:0]);
        cmd_wr({1'b0, ~rd_mode, a[13:8]});
    endtask

    task automatic data_write(input logic [7:0] d);
        logic [7:0] dummy;
        access(1'b0, 1'b1, d, dummy);
    endtask

    task automatic data_read(output logic [7:0] d);
        access(1'b0, 1'b0, 8'h00, d);
    endtask

    task automatic stat_read(output logic [7:0] d);
        access(1'b1, 1'b0, 8'h00, d);
    endtask

    task automatic pulse(input logic f, input logic s, input logic c, input logic [4:0] ix);
        @(negedge clk);
        frame_evt = f; fifth_evt = s; coll_evt = c; fifth_idx = ix;
        @(negedge clk);
        frame_evt = 1'b0; fifth_evt = 1'b0; coll_evt = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_regs(string tag);
        for (int i = 0; i < 8; i++)
            chk(tag, ctrl_regs[i*8 +: 8], ref_regs[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [13:0] a;
        int wc, rc;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = init_val(i);
            ref_mem[i] = init_val(i);
        end
        for (int i = 0; i < 8; i++) ref_regs[i] = 8'h00;
        host_cmd = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state at the ports
        chk("R1 status", host_rdata, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 regs", ctrl_regs, 64'h0);
        chk("R1 no access", wr_cnt + rd_cnt, 0);

        // R2: random register loads with junk in bits 6:3
        for (int k = 0; k < 16; k++)
            set_reg($urandom % 8, 8'($urandom), 8'($urandom));
        check_regs("R2 reg load");

        // R3: write address setup starts no access
        wc = wr_cnt; rc = rd_cnt;
        a = 14'($urandom);
        set_addr(a, 1'b0);
        chk("R3 no access", (wr_cnt - wc) + (rd_cnt - rc), 0);

        // R4: burst of writes at consecutive addresses
        for (int k = 0; k < 6; k++) begin
            logic [7:0] d = 8'($urandom);
            data_write(d);
            chk("R4 addr", last_waddr, 14'(a + 14'(k)));
            chk("R4 data", last_wdata, d);
            ref_mem[10'(a + 14'(k))] = d;
        end
        chk("R4 one write each", wr_cnt - wc, 6);

        // R5: write address wrap
        set_addr(14'h3FFE, 1'b0);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] d = 8'(8'hA0 + k);
            data_write(d);
            chk("R5 wrap addr", last_waddr, 14'(14'h3FFE + 14'(k)));
            ref_mem[10'(14'h3FFE + 14'(k))] = d;
        end

        // R6: read setup with prefetch, sequential reads, read wrap
        a = 14'($urandom);
        set_addr(a, 1'b1);
        for (int k = 0; k < 4; k++) begin
            data_read(r);
            chk("R6 read seq", r, ref_mem[10'(a + 14'(k))]);
        end
        set_addr(14'h3FFF, 1'b1);
        data_read(r);
        chk("R6 read at top", r, ref_mem[10'h3FF]);
        data_read(r);
        chk("R5 R6 read wrap", r, ref_mem[10'h000]);

        // R4 R6: random write then read back
        for (int k = 0; k < 20; k++) begin
            logic [7:0] d = 8'($urandom);
            a = 14'($urandom);
            set_addr(a, 1'b0);
            data_write(d);
            ref_mem[a[9:0]] = d;
            set_addr(a, 1'b1);
            data_read(r);
            chk("R6 readback", r, d);
        end

        // R7 R8: status format and clear on read
        pulse(1'b1, 1'b0, 1'b0, 5'h00);
        stat_read(r);
        chk("R7 frame bit", r, 8'h80);
        stat_read(r);
        chk("R8 cleared", r, 8'h00);
        pulse(1'b0, 1'b1, 1'b1, 5'h13);
        pulse(1'b0, 1'b1, 1'b0, 5'h04);
        stat_read(r);
        chk("R7 fifth coll index held", r, 8'h73);
        stat_read(r);
        chk("R8 index kept", r, 8'h13);
        // R8: event in the same cycle as the read
        @(negedge clk);
        host_cmd = 1'b1; host_rd = 1'b1; frame_evt = 1'b1;
        #2 r = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; frame_evt = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 old value", r, 8'h13);
        stat_read(r);
        chk("R8 event wins", r, 8'h93);

        // R9: interrupt gating with register 1 bit 5
        set_reg(1, 8'h00, 8'h00);
        pulse(1'b1, 1'b0, 1'b0, 5'h00);
        chk("R9 gated off", irq, 1'b0);
        set_reg(1, 8'h20, 8'h00);
        chk("R9 enabled", irq, 1'b1);
        stat_read(r);
        chk("R9 cleared by read", irq, 1'b0);

        // R10: status read and data access reset the toggle
        cmd_wr(8'h55);
        stat_read(r);
        set_reg(3, 8'h3C, 8'h00);
        check_regs("R10 after status read");
        cmd_wr(8'h11);
        data_read(r);
        set_reg(2, 8'h5A, 8'h28);
        check_regs("R10 after data read");
        cmd_wr(8'h66);
        data_write(8'h01);
        set_reg(6, 8'hC3, 8'h00);
        check_regs("R10 after data write");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule